// File: doc/BRIEF.md
# Backward-Pass Noise Management Scaler

This block sits on the error path in front of an analog array that computes the backward product z = Wᵀδ. It takes in a δ vector of `VEC_LEN` signed elements and stores them. While they arrive, it tracks the largest element magnitude δmax. It then divides every element by δmax. Each quotient leaves the block as a pulse-width code with a separate sign bit. The widest code, 2^PW−1, stands for unity. At least one driven input therefore reaches full scale, however small the δ values are.

After the last code has been accepted, the block waits for `OUT_LEN` digitized readbacks from the array. It multiplies each readback by the same δmax and emits it as a result. The whole result is then z = Wᵀδ + σ·δmax, so the analog noise term scales with the signal. A bypass input replaces δmax with a fixed unity scale of 2^(DW−1), which lets the normalization be switched off layer by layer. An all-zero vector produces zero codes and zero results, and no division is carried out for it.

States and transitions:
- LOAD accepts elements. On the last element, *load_done* goes to DIV_START.
- DIV_START launches one division. *div_issued* goes to DIV_WAIT.
- DIV_WAIT holds until the divider finishes. *div_done* goes to DRIVE.
- DRIVE presents the code. *drv_next* returns to DIV_START when elements remain. *drv_last* goes to READ after the last element.
- READ rescales readbacks. *read_done* returns to LOAD after `OUT_LEN` readbacks.

Top module: `nm_scaler`

## Requirements
- R1: After reset, in_ready is 1, drv_valid is 0 and res_valid is 0.
- R2: Exactly VEC_LEN elements are accepted per vector (in_valid and in_ready high at a clock edge). After the last one, in_ready stays 0 until the vector's readbacks are done.
- R3: drv_valid is never high while in_ready is high, so no element is driven before the whole vector has been loaded.
- R4: drv_code equals floor(|δ|·2^PW / scale), saturated at 2^PW−1. Here scale is δmax in normal mode and 2^(DW−1) in bypass mode.
- R5: In normal mode with a nonzero vector, every element whose magnitude equals δmax is driven with the full-scale code 2^PW−1.
- R6: drv_neg is 1 exactly when the element is negative (two's complement sign bit set).
- R7: Codes are driven in arrival order. Each code stays on drv_code and drv_neg, with drv_valid high, until drv_ready is seen high.
- R8: During READ, each rb_valid gives res_valid one cycle later, with res_data = rb_data × scale as a signed (RW+DW)-bit value.
- R9: After OUT_LEN readbacks, the block returns to LOAD and in_ready is 1 in the next cycle.
- R10: rb_valid outside READ is ignored and produces no res_valid.
- R11: bypass is sampled together with the last element of a vector. When it is set, scale is 2^(DW−1) for both the division and the multiplication.
- R12: In normal mode, an all-zero vector gives drv_code 0 for every element and res_data 0 for every readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass | input | 1 | Use unity scale 2^(DW−1) instead of δmax |
| in_valid | input | 1 | δ element valid |
| in_data | input | DW | Signed δ element |
| in_ready | output | 1 | Block is loading a vector |
| drv_valid | output | 1 | Drive code valid |
| drv_code | output | PW | Pulse-width code, 2^PW−1 = unity |
| drv_neg | output | 1 | Drive polarity, 1 = negative |
| drv_ready | input | 1 | Array accepts the current code |
| rb_valid | input | 1 | Digitized readback valid |
| rb_data | input | RW | Signed readback |
| res_valid | output | 1 | Rescaled result valid |
| res_data | output | RW+DW | Signed rescaled result |

## Verification
A wrong δmax shows up within a few cycles of the first drive. The largest element would no longer carry code 2^PW−1, or another element would carry a code other than the expected quotient. Either error surfaces at the first drive handshake, and the same wrong scale appears again in every rescaled result one cycle after each readback. A wrong element index or a lost state shows up at once, as codes out of arrival order, a code that changes while stalled, a missing result, or in_ready failing to return after the last readback. The scoreboard catches each of these at the handshake where it first appears.

// File: rtl/nm_pkg.sv
package nm_pkg;
    typedef enum logic [2:0] {
        S_LOAD      = 3'd0,
        S_DIV_START = 3'd1,
        S_DIV_WAIT  = 3'd2,
        S_DRIVE     = 3'd3,
        S_READ      = 3'd4
    } nm_state_e;
endpackage

// File: rtl/nm_absmax.sv
// Magnitude of the incoming element and running maximum over one vector.
module nm_absmax #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] mag,
    output logic [DW-1:0] max_nxt,
    output logic [DW-1:0] max_q
);
    // Two's complement magnitude; the most negative value maps to 2^(DW-1).
    always_comb begin
        mag = din[DW-1] ? (~din + 1'b1) : din;
        if (first)
            max_nxt = mag;
        else
            max_nxt = (mag > max_q) ? mag : max_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            max_q <= '0;
        else if (en)
            max_q <= max_nxt;
    end
endmodule

// File: rtl/nm_frac_div.sv
// Restoring fractional divider: quot = floor(num * 2^PW / den), saturating.
module nm_frac_div #(
    parameter int DW = 12,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [PW-1:0] quot
);
    localparam int CW = $clog2(PW + 1);
    localparam logic [PW-1:0] FULL = {PW{1'b1}};

    logic [DW:0]   rem;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   rem_sh;
    logic          ge;

    always_comb begin
        rem_sh = {rem[DW-1:0], 1'b0};
        ge     = (rem_sh >= {1'b0, den});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            quot <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= {1'b0, num};
                quot <= '0;
                if (den == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (num >= den) begin
                    quot <= FULL;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    cnt  <= CW'(PW);
                end
            end else if (busy) begin
                quot <= {quot[PW-2:0], ge};
                rem  <= ge ? (rem_sh - {1'b0, den}) : rem_sh;
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nm_rescale.sv
// Multiplies each accepted readback by the vector scale; one register stage.
module nm_rescale #(
    parameter int DW = 12,
    parameter int RW = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [RW-1:0]    rb,
    input  logic [DW-1:0]    scale,
    output logic             res_valid,
    output logic [RW+DW-1:0] res_data
);
    logic signed [RW+DW:0] prod;

    always_comb begin
        prod = $signed(rb) * $signed({1'b0, scale});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= en;
            if (en)
                res_data <= prod[RW+DW-1:0];
        end
    end
endmodule

// File: rtl/nm_scaler.sv
module nm_scaler #(
    parameter int VEC_LEN = 4,
    parameter int DW      = 12,
    parameter int PW      = 8,
    parameter int RW      = 14,
    parameter int OUT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             drv_valid,
    output logic [PW-1:0]    drv_code,
    output logic             drv_neg,
    input  logic             drv_ready,
    input  logic             rb_valid,
    input  logic [RW-1:0]    rb_data,
    output logic             res_valid,
    output logic [RW+DW-1:0] res_data
);
    import nm_pkg::*;

    localparam int IW = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
    localparam int OW = $clog2(OUT_LEN + 1);
    localparam logic [IW-1:0] LAST_IDX  = IW'(VEC_LEN - 1);
    localparam logic [OW-1:0] LAST_RB   = OW'(OUT_LEN - 1);
    localparam logic [DW-1:0] UNITY_SCL = {1'b1, {(DW-1){1'b0}}};

    nm_state_e state, nxt;

    logic [IW-1:0] idx;
    logic [OW-1:0] rcnt;
    logic [DW-1:0] scale;
    logic [PW-1:0] code_q;
    logic [DW-1:0] mag_buf [VEC_LEN];
    logic          neg_buf [VEC_LEN];

    logic          in_acc;
    logic          drv_acc;
    logic          rb_acc;
    logic [DW-1:0] mag;
    logic [DW-1:0] max_nxt;
    logic [DW-1:0] max_q;
    logic          div_done;
    logic [PW-1:0] div_quot;

    always_comb begin
        in_acc  = (state == S_LOAD)  && in_valid;
        drv_acc = (state == S_DRIVE) && drv_ready;
        rb_acc  = (state == S_READ)  && rb_valid;
    end

    nm_absmax #(.DW(DW)) u_absmax (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_acc),
        .first   (idx == '0),
        .din     (in_data),
        .mag     (mag),
        .max_nxt (max_nxt),
        .max_q   (max_q)
    );

    nm_frac_div #(.DW(DW), .PW(PW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == S_DIV_START),
        .num   (mag_buf[idx]),
        .den   (scale),
        .done  (div_done),
        .quot  (div_quot)
    );

    nm_rescale #(.DW(DW), .RW(RW)) u_rescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rb_acc),
        .rb        (rb_data),
        .scale     (scale),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_LOAD;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_LOAD:      if (in_valid && idx == LAST_IDX) nxt = S_DIV_START; // load_done
            S_DIV_START: nxt = S_DIV_WAIT;                                    // div_issued
            S_DIV_WAIT:  if (div_done) nxt = S_DRIVE;                         // div_done
            S_DRIVE:     if (drv_ready)
                             nxt = (idx == LAST_IDX) ? S_READ : S_DIV_START;  // drv_last / drv_next
            S_READ:      if (rb_valid && rcnt == LAST_RB) nxt = S_LOAD;       // read_done
            default:     nxt = S_LOAD;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            rcnt   <= '0;
            scale  <= '0;
            code_q <= '0;
        end else begin
            if (in_acc) begin
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                if (idx == LAST_IDX)
                    scale <= bypass ? UNITY_SCL : max_nxt;
            end
            if (state == S_DIV_WAIT && div_done)
                code_q <= div_quot;
            if (drv_acc)
                idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            if (rb_acc)
                rcnt <= (rcnt == LAST_RB) ? '0 : rcnt + 1'b1;
        end
    end

    // Element buffer
    always_ff @(posedge clk) begin
        if (in_acc) begin
            mag_buf[idx] <= mag;
            neg_buf[idx] <= in_data[DW-1];
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state == S_LOAD);
        drv_valid = (state == S_DRIVE);
        drv_code  = code_q;
        drv_neg   = neg_buf[idx];
    end
endmodule

// File: rtl/nm_scaler_chk.sv
module nm_scaler_chk #(
    parameter int DW = 12,
    parameter int PW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              drv_valid,
    input logic              drv_ready,
    input logic [PW-1:0]     drv_code,
    input logic              drv_neg,
    input logic              rb_valid,
    input logic              res_valid,
    input nm_pkg::nm_state_e state,
    input logic [DW-1:0]     scale
);
    import nm_pkg::*;

    p_load_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !drv_valid);

    p_hold_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid && !drv_ready |=> drv_valid && $stable(drv_code) && $stable(drv_neg));

    p_result_after_rb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rb_valid));

    p_stray_rb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid && state != S_READ |=> !res_valid);

    p_zero_scale_r12: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid && scale == '0 |-> drv_code == '0);
endmodule

bind nm_scaler nm_scaler_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .drv_valid (drv_valid),
    .drv_ready (drv_ready),
    .drv_code  (drv_code),
    .drv_neg   (drv_neg),
    .rb_valid  (rb_valid),
    .res_valid (res_valid),
    .state     (state),
    .scale     (scale)
);

// File: tb/nm_scaler_bench.sv
`timescale 1ns/1ps
module nm_scaler_bench;
    localparam int N  = 4;
    localparam int DW = 12;
    localparam int PW = 8;
    localparam int RW = 14;
    localparam int OL = 3;
    localparam int FULL = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, drv_valid, drv_neg, res_valid;
    logic [PW-1:0] drv_code;
    logic drv_ready = 1'b0;
    logic rb_valid = 1'b0;
    logic [RW-1:0] rb_data = '0;
    logic [RW+DW-1:0] res_data;

    always #2.5 clk = ~clk;

    nm_scaler u_nm_scaler (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .drv_valid(drv_valid), .drv_code(drv_code), .drv_neg(drv_neg), .drv_ready(drv_ready),
        .rb_valid(rb_valid), .rb_data(rb_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ndrv = 0;
    bit finished = 0;
    bit r3_bad = 0;
    int exp_code_q[$];
    bit exp_neg_q[$];
    int exp_res_q[$];
    int got_val[N];
    int lfsr = 7;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int m, input int s);
        int q;
        if (s == 0) return 0;
        q = (m << PW) / s;
        return (q > FULL) ? FULL : q;
    endfunction

    // Monitor: drive handshake with periodic stalls, result comparison, R3 watch
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            drv_ready = (cyc % 3) != 1;
            if (in_ready && drv_valid) r3_bad = 1;
            if (drv_valid && drv_ready) begin
                int ec; bit en;
                if (exp_code_q.size() == 0) begin
                    check(0, "R7 unexpected drive", int'(drv_code), -1);
                end else begin
                    ec = exp_code_q.pop_front();
                    en = exp_neg_q.pop_front();
                    check(int'(drv_code) == ec, (ec == FULL) ? "R4/R5 code" : "R4 code",
                          int'(drv_code), ec);
                    check(drv_neg == en, "R6 sign", int'(drv_neg), int'(en));
                end
                got_val[ndrv % N] = drv_neg ? -int'(drv_code) : int'(drv_code);
                ndrv++;
            end
            if (res_valid) begin
                if (exp_res_q.size() == 0)
                    check(0, "R10 unexpected result", int'($signed(res_data)), 0);
                else begin
                    int er;
                    er = exp_res_q.pop_front();
                    check(int'($signed(res_data)) == er, "R8 rescale", int'($signed(res_data)), er);
                end
            end
        end
    end

    task automatic run_vec(input int v0, input int v1, input int v2, input int v3, input bit byp);
        int v[N];
        int scl, mx, target;
        v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
        mx = 0;
        for (int j = 0; j < N; j++) begin
            int m;
            m = (v[j] < 0) ? -v[j] : v[j];
            if (m > mx) mx = m;
        end
        scl = byp ? (1 << (DW - 1)) : mx;
        for (int j = 0; j < N; j++) begin
            exp_code_q.push_back(exp_code((v[j] < 0) ? -v[j] : v[j], scl));
            exp_neg_q.push_back(v[j] < 0);
        end
        r3_bad = 0;
        // R10: stray readback while loading
        @(negedge clk);
        rb_valid = 1'b1; rb_data = RW'(123);
        @(negedge clk);
        rb_valid = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R10 stray readback", int'(res_valid), 0);
        // Load (R11: bypass sampled with the last element)
        target = ndrv + N;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = DW'(v[j]);
            bypass = byp;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        bypass = 1'b0;
        check(in_ready == 1'b0, "R2 ready low after last", int'(in_ready), 0);
        while (ndrv < target) @(negedge clk);
        check(r3_bad == 0, "R3 drive while loading", int'(r3_bad), 0);
        // Array model: ternary weights plus small noise
        for (int i = 0; i < OL; i++) begin
            int z;
            z = 0;
            for (int j = 0; j < N; j++) z += (((i + j) % 3) - 1) * got_val[j];
            lfsr = (lfsr * 5 + 3) % 7;
            z += lfsr - 3;
            exp_res_q.push_back(z * scl);
            @(negedge clk);
            rb_valid = 1'b1;
            rb_data = RW'(z);
        end
        @(negedge clk);
        rb_valid = 1'b0;
        check(in_ready == 1'b1, "R9 back to load", int'(in_ready), 1);
        @(negedge clk);
        check(exp_res_q.size() == 0, "R8 all results seen", exp_res_q.size(), 0);
        check(exp_code_q.size() == 0, "R2 all codes driven", exp_code_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && drv_valid == 1'b0 && res_valid == 1'b0, "R1 reset state",
              {29'd0, in_ready, drv_valid, res_valid}, 4);
        rst_n = 1'b1;
        run_vec(100, -400, 37, -5, 1'b0);      // R4 R5 R6 general
        run_vec(3, -1, 2, 0, 1'b0);            // R5 tiny vector still full scale
        run_vec(-2048, 1000, -1, 2047, 1'b0);  // R4 most negative magnitude
        run_vec(0, 0, 0, 0, 1'b0);             // R12 zero vector
        run_vec(500, -1024, 7, 0, 1'b1);       // R11 bypass
        run_vec(-9, 9, 1, -2, 1'b0);           // R5 tied maxima
        run_vec(600, 2, -3, 4, 1'b0);          // R11 bypass not sticky
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule